// File: doc/BRIEF.md
# Wraparound bit-range mask generator

This block turns a pair of bit indices into a 64-bit field-select mask for rotate-and-mask style datapaths. Indices count from the most significant end: index 0 names the leftmost (most significant) bit and index 63 the rightmost. Every bit whose index lies in the selected range is set to one, and every other bit is zero.

If the first index (`start_i`) is at most the second (`stop_i`), the range is the plain inclusive span between them. If `start_i` is larger, the span wraps across the word boundary. It then covers `start_i` up to 63 and 0 up to `stop_i`, and leaves a zero gap strictly between the two.

A parameter selects a registered output stage. That stage delays the mask and the accompanying valid strobe by one clock and is cleared by synchronous reset. The rotation itself and the decoding that supplies the indices are outside this block.

Top module: `rmask_gen`

## Requirements
- R1: Index k refers to vector bit `mask_o[63-k]`, so index 0 is `mask_o[63]` and index 63 is `mask_o[0]`.
- R2: When `start_i <= stop_i`, the bits at indices `start_i` through `stop_i` inclusive are one and all others are zero.
- R3: When `start_i > stop_i`, the bits at indices `start_i`..63 and 0..`stop_i` are one, and the bits at indices strictly between `stop_i` and `start_i` are zero.
- R4: When `start_i == stop_i`, exactly one bit of the mask is set.
- R5: `start_i=0, stop_i=63` gives all ones, and any wrap pair with `start_i == stop_i+1` also gives all ones.
- R6: With the registered stage enabled (default), `mask_o` and `valid_o` show the result for the inputs sampled at the previous rising clock edge, and `valid_o` copies `valid_i` with one cycle of delay.
- R7: A high `rst_i` at a rising edge clears `mask_o` and `valid_o` to zero at that edge, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the output register |
| rst_i | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Marks the index pair as meaningful |
| start_i | input | 6 | First index of the range, MSB-first numbering |
| stop_i | input | 6 | Last index of the range, MSB-first numbering |
| mask_o | output | 64 | Generated range mask |
| valid_o | output | 1 | Valid strobe matching `mask_o` |

## Verification
The checks on the combinational mask assume that `start_i` and `stop_i` carry known values in every cycle in which `valid_i` is high. The output-stage properties assume that `valid_i` is known at every clock edge outside reset. The bench meets both conditions: it drives every input to a defined level from time zero, changes the inputs only at falling edges, and holds reset high through the first edges. Because the index ports are six bits wide, no index can fall outside 0..63. The exhaustive sweep therefore covers the whole legal input space.

// File: rtl/rmask_pkg.sv
package rmask_pkg;
    parameter int unsigned RM_WIDTH = 64;
    localparam int unsigned RM_IDX_W = $clog2(RM_WIDTH);

    typedef struct packed {
        logic                valid;
        logic [RM_WIDTH-1:0] mask;
    } rm_out_t;
endpackage

// File: rtl/rmask_bound.sv
// Thermometer of one bound: selects every position at or after (KEEP_AFTER=1)
// or at or before (KEEP_AFTER=0) the given MSB-first index.
module rmask_bound #(
    parameter int unsigned W          = 64,
    parameter int unsigned IDX_W      = 6,
    parameter bit          KEEP_AFTER = 1'b1
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic [W-1:0]     sel_o
);
    for (genvar j = 0; j < W; j++) begin : g_pos
        localparam logic [IDX_W-1:0] POS = IDX_W'(W - 1 - j);
        if (KEEP_AFTER) begin : g_after
            assign sel_o[j] = (POS >= idx_i);
        end else begin : g_before
            assign sel_o[j] = (POS <= idx_i);
        end
    end
endmodule

// File: rtl/rmask_merge.sv
// Joins the two thermometers: intersection for a plain span, union on wrap.
module rmask_merge #(
    parameter int unsigned W     = 64,
    parameter int unsigned IDX_W = 6
) (
    input  logic [IDX_W-1:0] start_i,
    input  logic [IDX_W-1:0] stop_i,
    output logic [W-1:0]     mask_o
);
    logic [W-1:0] from_start;
    logic [W-1:0] upto_stop;
    logic         wraps;

    rmask_bound #(.W(W), .IDX_W(IDX_W), .KEEP_AFTER(1'b1)) u_lo (
        .idx_i (start_i),
        .sel_o (from_start)
    );

    rmask_bound #(.W(W), .IDX_W(IDX_W), .KEEP_AFTER(1'b0)) u_hi (
        .idx_i (stop_i),
        .sel_o (upto_stop)
    );

    always_comb begin
        wraps  = (start_i > stop_i);
        mask_o = wraps ? (from_start | upto_stop) : (from_start & upto_stop);
    end
endmodule

// File: rtl/rmask_outstage.sv
module rmask_outstage #(
    parameter bit REG_OUT = 1'b1
) (
    input  logic                                clk_i,
    input  logic                                rst_i,
    input  logic                                valid_i,
    input  logic [rmask_pkg::RM_WIDTH-1:0]      mask_i,
    output logic                                valid_o,
    output logic [rmask_pkg::RM_WIDTH-1:0]      mask_o
);
    import rmask_pkg::*;

    rm_out_t out_d;

    always_comb begin
        out_d.valid = valid_i;
        out_d.mask  = mask_i;
    end

    if (REG_OUT) begin : g_reg
        rm_out_t out_q;

        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                out_q <= '0;
            end else begin
                out_q <= out_d;
            end
        end

        assign valid_o = out_q.valid;
        assign mask_o  = out_q.mask;

        // R6: strobe is delayed by exactly one cycle
        p_valid_delay_r6: assert property (@(posedge clk_i) disable iff (rst_i)
            valid_i |=> valid_o);
        p_idle_delay_r6: assert property (@(posedge clk_i) disable iff (rst_i)
            !valid_i |=> !valid_o);
        // R7: synchronous reset empties the stage
        p_reset_clear_r7: assert property (@(posedge clk_i)
            rst_i |=> (!valid_o && mask_o == '0));
    end else begin : g_pass
        assign valid_o = out_d.valid;
        assign mask_o  = out_d.mask;
    end
endmodule

// File: rtl/rmask_gen.sv
module rmask_gen #(
    parameter int unsigned W       = rmask_pkg::RM_WIDTH,
    parameter bit          REG_OUT = 1'b1,
    localparam int unsigned IDX_W  = $clog2(W)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             valid_i,
    input  logic [IDX_W-1:0] start_i,
    input  logic [IDX_W-1:0] stop_i,
    output logic [W-1:0]     mask_o,
    output logic             valid_o
);
    logic [W-1:0] mask_c;

    rmask_merge #(.W(W), .IDX_W(IDX_W)) u_merge (
        .start_i (start_i),
        .stop_i  (stop_i),
        .mask_o  (mask_c)
    );

    rmask_outstage #(.REG_OUT(REG_OUT)) u_out (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .valid_i (valid_i),
        .mask_i  (mask_c),
        .valid_o (valid_o),
        .mask_o  (mask_o)
    );

    // R1: both end indices map to mask bit W-1-index and are set
    p_endpoints_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_i |-> (mask_c[W-1-int'(start_i)] && mask_c[W-1-int'(stop_i)]));
    // R2: plain span population equals its inclusive length
    p_span_count_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_i && start_i <= stop_i) |->
            ($countones(mask_c) == int'(stop_i) - int'(start_i) + 1));
    // R3: wrapped span leaves a gap of start-stop-1 zero bits
    p_wrap_count_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_i && start_i > stop_i) |->
            ($countones(mask_c) == int'(W) - (int'(start_i) - int'(stop_i) - 1)));
    // R4: equal indices select exactly one bit
    p_single_bit_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_i && start_i == stop_i) |-> $onehot0(mask_c) && (mask_c != '0));
endmodule

// File: tb/rmask_gen_tb.sv
module rmask_gen_tb_top;
    localparam int W = 64;

    logic         clk_i = 1'b0;
    logic         rst_i = 1'b1;
    logic         valid_i = 1'b0;
    logic [5:0]   start_i = '0;
    logic [5:0]   stop_i = '0;
    logic [W-1:0] mask_o;
    logic         valid_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk_i = ~clk_i;

    rmask_gen dut_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .valid_i (valid_i),
        .start_i (start_i),
        .stop_i  (stop_i),
        .mask_o  (mask_o),
        .valid_o (valid_o)
    );

    function automatic logic [W-1:0] ref_mask(int s, int e);
        logic [W-1:0] m = '0;
        for (int i = 0; i < W; i++) begin
            bit in_rng = (s <= e) ? (i >= s && i <= e) : (i >= s || i <= e);
            m[W-1-i] = in_rng;
        end
        return m;
    endfunction

    task automatic check(string req, logic [W-1:0] got, logic [W-1:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // drive at a falling edge, sample one full cycle later
    task automatic apply(int s, int e, bit v);
        @(negedge clk_i);
        start_i = 6'(s);
        stop_i  = 6'(e);
        valid_i = v;
        @(negedge clk_i);
    endtask

    task automatic t_reset_r7();
        rst_i = 1'b1;
        apply(5, 40, 1'b1);
        check("R7 mask under reset", mask_o, '0);
        check("R7 valid under reset", {63'd0, valid_o}, '0);
        @(negedge clk_i);
        rst_i = 1'b0;
    endtask

    task automatic t_numbering_r1();
        apply(0, 0, 1'b1);
        check("R1 index0 is msb", mask_o, {1'b1, 63'd0});
        apply(63, 63, 1'b1);
        check("R1 index63 is lsb", mask_o, 64'd1);
    endtask

    task automatic t_single_r4();
        for (int k = 0; k < W; k += 9) begin
            apply(k, k, 1'b1);
            check("R4 single bit", mask_o, 64'd1 << (W - 1 - k));
        end
    endtask

    task automatic t_span_r2();
        apply(4, 11, 1'b1);
        check("R2 span 4..11", mask_o, 64'h0FF0_0000_0000_0000);
        apply(32, 63, 1'b1);
        check("R2 low half", mask_o, 64'h0000_0000_FFFF_FFFF);
    endtask

    task automatic t_wrap_r3();
        apply(60, 3, 1'b1);
        check("R3 wrap 60..3", mask_o, 64'hF000_0000_0000_000F);
        apply(63, 0, 1'b1);
        check("R3 wrap ends only", mask_o, 64'h8000_0000_0000_0001);
    endtask

    task automatic t_full_r5();
        apply(0, 63, 1'b1);
        check("R5 full span", mask_o, '1);
        apply(17, 16, 1'b1);
        check("R5 wrap full", mask_o, '1);
        apply(1, 0, 1'b1);
        check("R5 wrap full 1,0", mask_o, '1);
    endtask

    task automatic t_valid_r6();
        apply(8, 15, 1'b0);
        check("R6 valid low follows", {63'd0, valid_o}, 64'd0);
        check("R6 mask delayed", mask_o, 64'h00FF_0000_0000_0000);
        @(negedge clk_i);
        start_i = 6'd0; stop_i = 6'd7; valid_i = 1'b1;
        #1;
        check("R6 output not yet updated", mask_o, 64'h00FF_0000_0000_0000);
        @(negedge clk_i);
        check("R6 valid high follows", {63'd0, valid_o}, 64'd1);
        check("R6 mask one cycle later", mask_o, 64'hFF00_0000_0000_0000);
    endtask

    task automatic t_sweep_r2_r3();
        for (int s = 0; s < W; s++) begin
            for (int e = 0; e < W; e++) begin
                apply(s, e, 1'b1);
                check((s <= e) ? "R2 sweep" : "R3 sweep", mask_o, ref_mask(s, e));
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk_i);
        t_reset_r7();
        t_numbering_r1();
        t_single_r4();
        t_span_r2();
        t_wrap_r3();
        t_full_r5();
        t_valid_r6();
        t_sweep_r2_r3();
        t_reset_r7();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk_i);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog R1..all got=hung exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule